// File: doc/BRIEF.md
# Two-Wide Register Rename Map with Free List

This block renames up to two decoded instructions per cycle. Each logical register specifier is translated into a physical register number from a larger pool. Source operands are looked up in a map table. Each instruction that writes a register receives a fresh physical register, taken from a FIFO of free physical register numbers, and the map is updated so that later readers see the newest copy. Because every new value lands in its own physical register, write-after-write and write-after-read hazards between instructions go away. An instruction that overwrites a register an older one still reads is never held back for that reason.

The two slots of a group are ordered: slot 0 is older than slot 1. When slot 1 reads or rewrites the logical register that slot 0 writes, it sees slot 0's new physical register and not the stale table entry. Each renamed destination is returned together with the physical register it displaced, so that retirement can later hand that register back through the two-slot release port. If the free list cannot cover every destination in the group, the whole group stalls. Nothing is allocated and the map is not touched, so the upstream stage simply presents the same group again.

Top module: `rename_map_unit`

## Requirements
- R1: After reset, logical register k maps to physical register k for every k below NUM_LOG. The free list holds NUM_LOG to NUM_PHYS-1 in ascending order. `stall` and `out_valid` are 0.
- R2: Every accepted slot's source fields come out one cycle later, carrying the physical register the map holds for that logical register (slot numbering: slot i uses bits [i*W +: W] of each bus).
- R3: Accepted slots with `in_dst_en` set take physical registers from the head of the free list in FIFO order, slot 0 before slot 1. The two numbers in one group are always different.
- R4: After a group is accepted, the map holds each written logical register's new physical register. When both slots write the same logical register, slot 1's value is the one kept.
- R5: If slot 0 writes logical register x and slot 1 reads x in the same group, slot 1's source field carries slot 0's newly allocated register.
- R6: `out_prev_phys` reports the mapping that each destination displaced. If both slots write the same logical register, slot 1 reports slot 0's new register.
- R7: `stall` is 1 exactly when the number of slots with both valid and destination enable exceeds the current free count. A stalled group changes neither the map nor the free list, and `out_valid` is 0 in the next cycle. A group whose demand equals the free count is accepted.
- R8: Registers on the release port are appended to the tail of the free list, slot 0 before slot 1. They count toward the free total from the next cycle on, and never in the cycle they arrive.
- R9: A slot without a destination consumes no free register. Its `out_dst_phys` and `out_prev_phys` fields read 0 and its `out_dst_en` bit is 0.
- R10: `out_valid` one cycle after a cycle with `stall` low equals that cycle's `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 2 | Slot valid bits, bit 0 is the older slot |
| in_dst_en | input | 2 | Slot writes a destination register |
| in_dst | input | 2*LOG_W | Destination logical register per slot |
| in_src_a | input | 2*LOG_W | First source logical register per slot |
| in_src_b | input | 2*LOG_W | Second source logical register per slot |
| rel_en | input | 2 | Release slot enables |
| rel_phys | input | 2*PHYS_W | Physical registers returned to the pool |
| stall | output | 1 | Group not accepted this cycle |
| out_valid | output | 2 | Renamed slot valid bits |
| out_dst_en | output | 2 | Renamed slot has a destination |
| out_src_a_phys | output | 2*PHYS_W | Physical register for the first source |
| out_src_b_phys | output | 2*PHYS_W | Physical register for the second source |
| out_dst_phys | output | 2*PHYS_W | Newly allocated destination register |
| out_prev_phys | output | 2*PHYS_W | Mapping displaced by the destination |

## Verification
Release and allocation can fall in the same cycle. The sharpest cases are releases arriving while a group stalls for lack of registers, and releases that land while the free list is nearly empty. A directed sequence first drains the pool to one entry. It then offers a two-destination group, releases two registers in that same stalled cycle, and retries. A long random phase follows, mixing releases with groups of random width and random register overlap. A reference model of the map and a queue of free numbers predicts every stall decision and every renamed field, and a monitor compares each registered output against that model.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
   localparam int unsigned RNM_SLOTS = 2;

   // number of slots that need a fresh physical register
   function automatic int unsigned slot_demand(input logic [1:0] vld, input logic [1:0] den);
      int unsigned n;
      n = 0;
      for (int i = 0; i < 2; i++) begin
         if (vld[i] && den[i]) n++;
      end
      return n;
   endfunction
endpackage

// File: rtl/rnm_free_fifo.sv
module rnm_free_fifo #(
   parameter int unsigned PHYS_W    = 4,
   parameter int unsigned DEPTH     = 16,
   parameter int unsigned INIT_CNT  = 8,
   parameter int unsigned INIT_BASE = 8,
   parameter int unsigned CNT_W     = $clog2(DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            pop_cnt,
   input  logic [1:0]            push_en,
   input  logic [2*PHYS_W-1:0]   push_data,
   output logic [PHYS_W-1:0]     head0,
   output logic [PHYS_W-1:0]     head1,
   output logic [CNT_W-1:0]      count
);
   localparam int unsigned PTR_W = $clog2(DEPTH);

   generate
      if ((1 << PTR_W) != DEPTH) begin : g_bad_depth
         $error("rnm_free_fifo: DEPTH must be a power of two");
      end
      if (INIT_CNT > DEPTH) begin : g_bad_init
         $error("rnm_free_fifo: INIT_CNT exceeds DEPTH");
      end
   endgenerate

   logic [PHYS_W-1:0] slots_q [DEPTH];
   logic [PTR_W-1:0]  rd_q, wr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [PTR_W-1:0]  wr_hi;

   assign wr_hi = wr_q + PTR_W'(push_en[0]);
   assign head0 = slots_q[rd_q];
   assign head1 = slots_q[rd_q + PTR_W'(1)];
   assign count = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= PTR_W'(INIT_CNT % DEPTH);
         cnt_q <= CNT_W'(INIT_CNT);
         for (int i = 0; i < int'(DEPTH); i++) begin
            slots_q[i] <= (i < int'(INIT_CNT)) ? PHYS_W'(int'(INIT_BASE) + i) : '0;
         end
      end else begin
         if (push_en[0]) slots_q[wr_q]  <= push_data[0 +: PHYS_W];
         if (push_en[1]) slots_q[wr_hi] <= push_data[PHYS_W +: PHYS_W];
         rd_q  <= rd_q + PTR_W'(pop_cnt);
         wr_q  <= wr_hi + PTR_W'(push_en[1]);
         cnt_q <= cnt_q - CNT_W'(pop_cnt) + CNT_W'(push_en[0]) + CNT_W'(push_en[1]);
      end
   end

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cnt_q) + int'(push_en[0]) + int'(push_en[1]) - int'(pop_cnt)) <= int'(DEPTH));

   p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pop_cnt) <= int'(cnt_q));
endmodule

// File: rtl/rnm_map_table.sv
module rnm_map_table #(
   parameter int unsigned NUM_LOG = 8,
   parameter int unsigned LOG_W   = 3,
   parameter int unsigned PHYS_W  = 4,
   parameter int unsigned N_RD    = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_RD*LOG_W-1:0]    rd_addr,
   output logic [N_RD*PHYS_W-1:0]   rd_data,
   input  logic                     we0,
   input  logic [LOG_W-1:0]         wa0,
   input  logic [PHYS_W-1:0]        wd0,
   input  logic                     we1,
   input  logic [LOG_W-1:0]         wa1,
   input  logic [PHYS_W-1:0]        wd1
);
   generate
      if ((1 << LOG_W) < NUM_LOG) begin : g_bad_width
         $error("rnm_map_table: LOG_W too narrow for NUM_LOG");
      end
   endgenerate

   logic [PHYS_W-1:0] map_q [NUM_LOG];

   generate
      for (genvar r = 0; r < int'(N_RD); r++) begin : g_rd
         assign rd_data[r*PHYS_W +: PHYS_W] = map_q[rd_addr[r*LOG_W +: LOG_W]];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < int'(NUM_LOG); k++) map_q[k] <= PHYS_W'(k);
      end else begin
         if (we0) map_q[wa0] <= wd0;
         if (we1) map_q[wa1] <= wd1;   // younger slot overrides
      end
   end
endmodule

// File: rtl/rename_map_unit.sv
module rename_map_unit #(
   parameter int unsigned NUM_LOG  = 8,
   parameter int unsigned NUM_PHYS = 16,
   parameter int unsigned LOG_W    = $clog2(NUM_LOG),
   parameter int unsigned PHYS_W   = $clog2(NUM_PHYS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            in_valid,
   input  logic [1:0]            in_dst_en,
   input  logic [2*LOG_W-1:0]    in_dst,
   input  logic [2*LOG_W-1:0]    in_src_a,
   input  logic [2*LOG_W-1:0]    in_src_b,
   input  logic [1:0]            rel_en,
   input  logic [2*PHYS_W-1:0]   rel_phys,
   output logic                  stall,
   output logic [1:0]            out_valid,
   output logic [1:0]            out_dst_en,
   output logic [2*PHYS_W-1:0]   out_src_a_phys,
   output logic [2*PHYS_W-1:0]   out_src_b_phys,
   output logic [2*PHYS_W-1:0]   out_dst_phys,
   output logic [2*PHYS_W-1:0]   out_prev_phys
);
   import rnm_pkg::*;

   localparam int unsigned FREE_INIT = NUM_PHYS - NUM_LOG;
   localparam int unsigned CNT_W     = $clog2(NUM_PHYS + 1);
   localparam int unsigned N_RD      = 3 * RNM_SLOTS;

   generate
      if (NUM_PHYS <= NUM_LOG) begin : g_bad_pool
         $error("rename_map_unit: NUM_PHYS must exceed NUM_LOG");
      end
      if (NUM_LOG < 2) begin : g_bad_log
         $error("rename_map_unit: NUM_LOG must be at least 2");
      end
   endgenerate

   logic [1:0]              want;
   logic [CNT_W-1:0]        need;
   logic [CNT_W-1:0]        fl_count;
   logic [PHYS_W-1:0]       fl_head0, fl_head1;
   logic                    accept;
   logic [PHYS_W-1:0]       alloc [2];
   logic [N_RD*LOG_W-1:0]   rd_addr;
   logic [N_RD*PHYS_W-1:0]  rd_data;
   logic [PHYS_W-1:0]       tbl_a [2], tbl_b [2], tbl_old [2];
   logic [PHYS_W-1:0]       ren_a [2], ren_b [2], ren_prev [2];

   assign want   = in_valid & in_dst_en;
   assign need   = CNT_W'(slot_demand(in_valid, in_dst_en));
   assign stall  = need > fl_count;
   assign accept = !stall;

   // slot 0 takes the head; slot 1 takes the next entry only if slot 0 took one
   assign alloc[0] = fl_head0;
   assign alloc[1] = want[0] ? fl_head1 : fl_head0;

   generate
      for (genvar s = 0; s < 2; s++) begin : g_slot
         assign rd_addr[(3*s+0)*LOG_W +: LOG_W] = in_src_a[s*LOG_W +: LOG_W];
         assign rd_addr[(3*s+1)*LOG_W +: LOG_W] = in_src_b[s*LOG_W +: LOG_W];
         assign rd_addr[(3*s+2)*LOG_W +: LOG_W] = in_dst[s*LOG_W +: LOG_W];
         assign tbl_a[s]   = rd_data[(3*s+0)*PHYS_W +: PHYS_W];
         assign tbl_b[s]   = rd_data[(3*s+1)*PHYS_W +: PHYS_W];
         assign tbl_old[s] = rd_data[(3*s+2)*PHYS_W +: PHYS_W];
         if (s == 0) begin : g_oldest
            assign ren_a[s]    = tbl_a[s];
            assign ren_b[s]    = tbl_b[s];
            assign ren_prev[s] = tbl_old[s];
         end else begin : g_younger
            logic hit_a, hit_b, hit_d;
            assign hit_a = want[0] && (in_src_a[s*LOG_W +: LOG_W] == in_dst[0 +: LOG_W]);
            assign hit_b = want[0] && (in_src_b[s*LOG_W +: LOG_W] == in_dst[0 +: LOG_W]);
            assign hit_d = want[0] && (in_dst[s*LOG_W +: LOG_W]   == in_dst[0 +: LOG_W]);
            assign ren_a[s]    = hit_a ? alloc[0] : tbl_a[s];
            assign ren_b[s]    = hit_b ? alloc[0] : tbl_b[s];
            assign ren_prev[s] = hit_d ? alloc[0] : tbl_old[s];
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               out_valid[s]                       <= 1'b0;
               out_dst_en[s]                      <= 1'b0;
               out_src_a_phys[s*PHYS_W +: PHYS_W] <= '0;
               out_src_b_phys[s*PHYS_W +: PHYS_W] <= '0;
               out_dst_phys[s*PHYS_W +: PHYS_W]   <= '0;
               out_prev_phys[s*PHYS_W +: PHYS_W]  <= '0;
            end else begin
               out_valid[s]                       <= accept && in_valid[s];
               out_dst_en[s]                      <= accept && want[s];
               out_src_a_phys[s*PHYS_W +: PHYS_W] <= ren_a[s];
               out_src_b_phys[s*PHYS_W +: PHYS_W] <= ren_b[s];
               out_dst_phys[s*PHYS_W +: PHYS_W]   <= want[s] ? alloc[s] : '0;
               out_prev_phys[s*PHYS_W +: PHYS_W]  <= want[s] ? ren_prev[s] : '0;
            end
         end
      end
   endgenerate

   rnm_map_table #(
      .NUM_LOG (NUM_LOG),
      .LOG_W   (LOG_W),
      .PHYS_W  (PHYS_W),
      .N_RD    (N_RD)
   ) u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .we0     (accept && want[0]),
      .wa0     (in_dst[0 +: LOG_W]),
      .wd0     (alloc[0]),
      .we1     (accept && want[1]),
      .wa1     (in_dst[LOG_W +: LOG_W]),
      .wd1     (alloc[1])
   );

   rnm_free_fifo #(
      .PHYS_W    (PHYS_W),
      .DEPTH     (NUM_PHYS),
      .INIT_CNT  (FREE_INIT),
      .INIT_BASE (NUM_LOG),
      .CNT_W     (CNT_W)
   ) u_free (
      .clk       (clk),
      .rst_n     (rst_n),
      .pop_cnt   (accept ? need[1:0] : 2'd0),
      .push_en   (rel_en),
      .push_data (rel_phys),
      .head0     (fl_head0),
      .head1     (fl_head1),
      .count     (fl_count)
   );

   p_alloc_distinct_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid == 2'b11 && out_dst_en == 2'b11) |->
      out_dst_phys[0 +: PHYS_W] != out_dst_phys[PHYS_W +: PHYS_W]);

   p_bypass_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && want[0] && in_valid[1] && in_src_a[LOG_W +: LOG_W] == in_dst[0 +: LOG_W]) |=>
      out_src_a_phys[PHYS_W +: PHYS_W] == out_dst_phys[0 +: PHYS_W]);

   p_waw_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && want == 2'b11 && in_dst[0 +: LOG_W] == in_dst[LOG_W +: LOG_W]) |=>
      out_prev_phys[PHYS_W +: PHYS_W] == out_dst_phys[0 +: PHYS_W]);

   p_stall_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> out_valid == 2'b00);

   p_dst_only_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_dst_en & ~out_valid) == 2'b00);
endmodule

// File: tb/rename_map_unit_test.sv
module rename_map_unit_test;
   localparam int NL = 8;
   localparam int NP = 16;
   localparam int LW = 3;
   localparam int PW = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [1:0]      in_valid = '0, in_dst_en = '0, rel_en = '0;
   logic [2*LW-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
   logic [2*PW-1:0] rel_phys = '0;
   logic            stall;
   logic [1:0]      out_valid, out_dst_en;
   logic [2*PW-1:0] out_src_a_phys, out_src_b_phys, out_dst_phys, out_prev_phys;

   always #5 clk = ~clk;

   rename_map_unit #(.NUM_LOG(NL), .NUM_PHYS(NP)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst_en(in_dst_en),
      .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
      .rel_en(rel_en), .rel_phys(rel_phys), .stall(stall),
      .out_valid(out_valid), .out_dst_en(out_dst_en),
      .out_src_a_phys(out_src_a_phys), .out_src_b_phys(out_src_b_phys),
      .out_dst_phys(out_dst_phys), .out_prev_phys(out_prev_phys));

   typedef struct packed {
      logic [1:0]         v;
      logic [1:0]         de;
      logic [1:0][PW-1:0] sa, sb, d, p;
   } exp_t;

   int n_checks = 0;
   int n_fail   = 0;
   exp_t        eq[$];
   logic [PW-1:0] fq[$];     // model free list
   logic [PW-1:0] rq[$];     // displaced registers awaiting release
   logic [PW-1:0] mdl_map [NL];

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // monitor: compare each renamed group against the scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid != 2'b00) begin
         if (eq.size() == 0) begin
            check("R10 unexpected out_valid", int'(out_valid), 0);
         end else begin
            exp_t e;
            e = eq.pop_front();
            check("R10 out_valid", int'(out_valid), int'(e.v));
            check("R9 out_dst_en", int'(out_dst_en), int'(e.de));
            for (int s = 0; s < 2; s++) begin
               if (e.v[s]) begin
                  check("R2 R4 R5 src_a", int'(out_src_a_phys[s*PW +: PW]), int'(e.sa[s]));
                  check("R2 R4 R5 src_b", int'(out_src_b_phys[s*PW +: PW]), int'(e.sb[s]));
                  check("R3 R8 R9 dst",   int'(out_dst_phys[s*PW +: PW]),   int'(e.d[s]));
                  check("R6 R9 prev",     int'(out_prev_phys[s*PW +: PW]),  int'(e.p[s]));
               end
            end
         end
      end
   end

   // driver: predicts the group, pushes the expectation, drives one cycle
   task automatic group(input bit v0, input bit d0, input int ds0, input int a0, input int b0,
                        input bit v1, input bit d1, input int ds1, input int a1, input int b1,
                        input int nrel);
      bit v[2], d[2], exp_stall, re[2];
      int ds[2], a[2], b[2], need;
      logic [PW-1:0] rel[2];
      exp_t e;
      v = '{v0, v1}; d = '{d0, d1}; ds = '{ds0, ds1}; a = '{a0, a1}; b = '{b0, b1};
      need = ((v0 && d0) ? 1 : 0) + ((v1 && d1) ? 1 : 0);
      exp_stall = need > fq.size();
      re = '{1'b0, 1'b0}; rel = '{'0, '0};
      for (int k = 0; k < nrel; k++) begin
         if (rq.size() > 0) begin re[k] = 1'b1; rel[k] = rq.pop_front(); end
      end
      for (int s = 0; s < 2; s++) begin
         in_valid[s]            = v[s];
         in_dst_en[s]           = d[s];
         in_dst[s*LW +: LW]     = LW'(ds[s]);
         in_src_a[s*LW +: LW]   = LW'(a[s]);
         in_src_b[s*LW +: LW]   = LW'(b[s]);
         rel_en[s]              = re[s];
         rel_phys[s*PW +: PW]   = rel[s];
      end
      #1;
      check("R7 stall", int'(stall), int'(exp_stall));
      if (!exp_stall && (v0 || v1)) begin
         e = '0;
         for (int s = 0; s < 2; s++) begin
            e.v[s] = v[s];
            if (v[s]) begin
               e.sa[s] = mdl_map[a[s]];
               e.sb[s] = mdl_map[b[s]];
               if (d[s]) begin
                  e.de[s] = 1'b1;
                  e.d[s]  = fq.pop_front();
                  e.p[s]  = mdl_map[ds[s]];
                  mdl_map[ds[s]] = e.d[s];
                  rq.push_back(e.p[s]);
               end
            end
         end
         eq.push_back(e);
      end
      for (int s = 0; s < 2; s++) if (re[s]) fq.push_back(rel[s]);
      @(posedge clk);
      @(negedge clk);
      in_valid = '0; rel_en = '0; in_dst_en = '0;
   endtask

   initial begin
      #2_000_000;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      for (int k = 0; k < NL; k++) mdl_map[k] = PW'(k);
      for (int k = NL; k < NP; k++) fq.push_back(PW'(k));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset stall", int'(stall), 0);
      check("R1 reset out_valid", int'(out_valid), 0);

      // R1 R2 R9: identity reads, no allocation
      group(1, 0, 0, 1, 2,  1, 0, 0, 3, 4, 0);
      // hazard sequence: r3=r3 op r5 ; r4=r3+1 (R5 bypass)
      group(1, 1, 3, 3, 5,  1, 1, 4, 3, 3, 0);
      // r3=r5+1 ; r7=r3 op r4 (R4 newest mapping, R5 bypass)
      group(1, 1, 3, 5, 5,  1, 1, 7, 3, 4, 0);
      // R4 R6: both write r2
      group(1, 1, 2, 2, 2,  1, 1, 2, 2, 2, 0);
      // leave one free entry
      group(1, 1, 6, 6, 0,  0, 0, 0, 0, 0, 0);
      // R7: demand 2 with 1 free stalls
      group(1, 1, 1, 1, 1,  1, 1, 0, 0, 0, 0);
      // R7: demand equal to free count is accepted
      group(0, 0, 0, 0, 0,  1, 1, 5, 2, 3, 0);
      // R7 R8: stall with releases arriving in the same cycle
      group(1, 1, 1, 1, 1,  1, 1, 0, 3, 0, 2);
      group(1, 1, 1, 1, 1,  1, 1, 0, 3, 0, 0);
      // R9: slot 1 with dst only, slot 0 without
      group(1, 0, 0, 7, 7,  1, 1, 7, 7, 1, 2);

      for (int it = 0; it < 400; it++) begin
         int nr;
         nr = (it % 7 < 3) ? 0 : int'($urandom % 3);
         group(1'($urandom), 1'($urandom), int'($urandom % NL), int'($urandom % NL), int'($urandom % NL),
               1'($urandom), 1'($urandom), int'($urandom % NL), int'($urandom % NL), int'($urandom % NL),
               nr);
      end
      repeat (2) @(negedge clk);
      check("R10 pending groups", eq.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule